// File: doc/BRIEF.md
# Bit-Slice Integer ALU

This block is a purely combinational arithmetic and logic unit for a word of parameterised width (32 bits by default). It is assembled from identical one-bit slices: each slice holds an AND gate, an OR gate and a full adder, and a small multiplexer picks one of them. The slices are chained through their carries, so that the word acts as a ripple-carry adder. The top slice carries extra logic that produces the signed overflow indication and the less-than decision.

Subtraction uses the same adder. A single control bit both inverts the B operand in every slice and forces the carry into bit 0, which gives A + ~B + 1. For set-on-less-than, the top slice produces the decision from the sign of A − B. That bit feeds the spare multiplexer input of bit 0, and every other slice presents zero on that input. A Zero flag, the NOR of all result bits, lets the block serve an equality test by subtraction. The block has no clock and no state. An operation code and the operands go in, and the result settles after the carry ripple.

Top module: `bitslice_alu`

## Requirements
- R1: Operation code 3'b000 gives the bitwise AND of A and B.
- R2: Operation code 3'b001 gives the bitwise OR of A and B.
- R3: Operation code 3'b010 gives A + B modulo 2^WIDTH.
- R4: Operation code 3'b110 gives A − B modulo 2^WIDTH, formed as A + ~B + 1. Bit 2 of the code inverts B and supplies the carry into bit 0.
- R5: Operation code 3'b111 gives 1 in bit 0 when A is less than B as signed two's complement values, and 0 otherwise. The comparison stays correct when A − B overflows. Bits WIDTH-1..1 of the result are always 0.
- R6: zero_o is 1 exactly when every bit of result_o is 0, for every operation code.
- R7: ovf_o is 1 for code 3'b010 when A + B overflows as a signed sum, and for code 3'b110 when A − B overflows as a signed difference. It is 0 for codes 3'b000, 3'b001 and 3'b111.
- R8: The unused codes 3'b011, 3'b100 and 3'b101 give an all-zero result and ovf_o = 0, whatever the operands are. As a result, zero_o is 1 for these codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | All result bits are zero |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The case that is hardest to reach is a set-on-less-than where A − B overflows. There the sign bit of the difference points the wrong way, and only the correction with the overflow term gives the right answer. Uniform random operands seldom have opposite signs with magnitudes near the extremes. The stimulus therefore pairs the most negative value, the most positive value, −1, 0 and 1 with each other under every operation code. It also includes directed vectors such as 0x80000000 against 0x7FFFFFFF.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 3;
  typedef logic [OP_W-1:0] alu_op_t;

  localparam alu_op_t OP_AND = 3'b000;
  localparam alu_op_t OP_OR  = 3'b001;
  localparam alu_op_t OP_ADD = 3'b010;
  localparam alu_op_t OP_SUB = 3'b110;
  localparam alu_op_t OP_SLT = 3'b111;

  // slice multiplexer selections
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;
endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import alu_pkg::*;
(
  input  alu_op_t    op,
  output logic       b_inv,
  output slice_sel_e sel,
  output logic       code_ok,
  output logic       arith
);
  always_comb begin
    b_inv   = 1'b0;
    sel     = SEL_AND;
    code_ok = 1'b1;
    arith   = 1'b0;
    unique case (op)
      OP_AND: sel = SEL_AND;
      OP_OR:  sel = SEL_OR;
      OP_ADD: begin sel = SEL_SUM; arith = 1'b1; end
      OP_SUB: begin sel = SEL_SUM; arith = 1'b1; b_inv = 1'b1; end
      OP_SLT: begin sel = SEL_LESS; b_inv = 1'b1; end
      default: code_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (x & ci) | (y & ci);
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       b_inv,
  input  logic       cin,
  input  logic       less,
  input  slice_sel_e sel,
  output logic       res,
  output logic       cout
);
  logic b_eff;
  logic sum;

  assign b_eff = b ^ b_inv;

  alu_full_adder u_fa (.x(a), .y(b_eff), .ci(cin), .s(sum), .co(cout));

  always_comb begin
    unique case (sel)
      SEL_AND:  res = a & b;
      SEL_OR:   res = a | b;
      SEL_SUM:  res = sum;
      SEL_LESS: res = less;
      default:  res = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       b_inv,
  input  logic       cin,
  input  logic       less,
  input  slice_sel_e sel,
  output logic       res,
  output logic       set,
  output logic       ovf
);
  logic b_eff;
  logic sum;
  logic cout;

  assign b_eff = b ^ b_inv;

  alu_full_adder u_fa (.x(a), .y(b_eff), .ci(cin), .s(sum), .co(cout));

  // signed overflow: carry into the sign bit differs from carry out of it
  assign ovf = cin ^ cout;
  // signed less-than of the difference, corrected for overflow
  assign set = sum ^ ovf;

  always_comb begin
    unique case (sel)
      SEL_AND:  res = a & b;
      SEL_OR:   res = a | b;
      SEL_SUM:  res = sum;
      SEL_LESS: res = less;
      default:  res = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec,
  output logic             all_zero
);
  assign all_zero = ~|vec;
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic             b_inv;
  slice_sel_e       sel;
  logic             code_ok;
  logic             arith;
  logic [MSB:0]     carry;
  logic [MSB:0]     raw_res;
  logic             slt_set;
  logic             msb_ovf;

  alu_ctrl_decode u_dec (
    .op(op_i), .b_inv(b_inv), .sel(sel), .code_ok(code_ok), .arith(arith)
  );

  assign carry[0] = b_inv;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == MSB) begin : g_top
      alu_msb_slice u_msb (
        .a(a_i[i]), .b(b_i[i]), .b_inv(b_inv), .cin(carry[i]),
        .less(1'b0), .sel(sel), .res(raw_res[i]),
        .set(slt_set), .ovf(msb_ovf)
      );
    end else if (i == 0) begin : g_lsb
      alu_slice u_bit (
        .a(a_i[i]), .b(b_i[i]), .b_inv(b_inv), .cin(carry[i]),
        .less(slt_set), .sel(sel), .res(raw_res[i]), .cout(carry[i+1])
      );
    end else begin : g_mid
      alu_slice u_bit (
        .a(a_i[i]), .b(b_i[i]), .b_inv(b_inv), .cin(carry[i]),
        .less(1'b0), .sel(sel), .res(raw_res[i]), .cout(carry[i+1])
      );
    end
  end

  assign result_o = code_ok ? raw_res : '0;
  assign ovf_o    = code_ok & arith & msb_ovf;

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (.vec(result_o), .all_zero(zero_o));
endmodule

// File: rtl/bitslice_alu_checker.sv
module bitslice_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      if (op_i == 3'b010)
        assert_add_R3: assert (result_o == a_i + b_i);
      if (op_i == 3'b110)
        assert_sub_R4: assert (result_o == a_i - b_i);
      if (op_i == 3'b111)
        assert_slt_upper_R5: assert (result_o[WIDTH-1:1] == '0);
      assert_zero_flag_R6: assert (zero_o == (result_o == '0));
      if (op_i == 3'b000 || op_i == 3'b001 || op_i == 3'b111)
        assert_no_overflow_R7: assert (!ovf_o);
      if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
        assert_undef_quiet_R8: assert (result_o == '0 && !ovf_o);
    end
  end
endmodule

bind bitslice_alu bitslice_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i),
  .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o)
);

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [2:0]  op = '0;
  logic [31:0] res;
  logic        zf;
  logic        vf;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitslice_alu #(.WIDTH(32)) u_bitslice_alu (
    .a_i(a), .b_i(b), .op_i(op), .result_o(res), .zero_o(zf), .ovf_o(vf)
  );

  // {op, a, b, expected result, expected zero, expected overflow}
  localparam logic [100:0] VEC [N_VEC] = '{
    {3'b000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0}, // R1
    {3'b000, 32'h12345678, 32'h00000000, 32'h00000000, 1'b1, 1'b0}, // R1 R6
    {3'b001, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'hFFFFFFFF, 1'b0, 1'b0}, // R2
    {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1}, // R3 R7
    {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R3 R6
    {3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1}, // R4 R7
    {3'b110, 32'h12345678, 32'h12345678, 32'h00000000, 1'b1, 1'b0}, // R4 R6
    {3'b111, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0}, // R5
    {3'b111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b1, 1'b0}, // R5
    {3'b111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0}, // R5
    {3'b111, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0}, // R5
    {3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0}, // R8
    {3'b100, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'h00000000, 1'b1, 1'b0}, // R8
    {3'b101, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}  // R8
  };

  function automatic logic [33:0] model(input logic [2:0] o,
                                        input logic [31:0] x,
                                        input logic [31:0] y);
    logic [31:0] r;
    logic v;
    r = '0;
    v = 1'b0;
    case (o)
      3'b000: r = x & y;
      3'b001: r = x | y;
      3'b010: begin r = x + y; v = (x[31] == y[31]) && (r[31] != x[31]); end
      3'b110: begin r = x - y; v = (x[31] != y[31]) && (r[31] != x[31]); end
      3'b111: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
    return {r, (r == 32'd0), v};
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] er,
                       input logic ez, input logic ev);
    checks++;
    if (res !== er) begin
      errors++;
      $display("FAIL %s result op=%b a=%h b=%h got=%h exp=%h", req, op, a, b, res, er);
    end
    checks++;
    if (zf !== ez) begin
      errors++;
      $display("FAIL R6 (%s) zero op=%b a=%h b=%h got=%b exp=%b", req, op, a, b, zf, ez);
    end
    checks++;
    if (vf !== ev) begin
      errors++;
      $display("FAIL R7 (%s) overflow op=%b a=%h b=%h got=%b exp=%b", req, op, a, b, vf, ev);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [33:0] e;
    logic [31:0] corner [5];
    corner[0] = 32'h00000000;
    corner[1] = 32'h00000001;
    corner[2] = 32'h7FFFFFFF;
    corner[3] = 32'h80000000;
    corner[4] = 32'hFFFFFFFF;

    // reset state: zero operands with AND
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 32'h0, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < N_VEC; i++) begin
      apply(VEC[i][100:98], VEC[i][97:66], VEC[i][65:34]);
      check(tag_of(VEC[i][100:98]), VEC[i][33:2], VEC[i][1], VEC[i][0]);
    end

    // corner operand pairs under every code (R5 overflowing compares)
    for (int o = 0; o < 8; o++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          apply(3'(o), corner[i], corner[j]);
          e = model(3'(o), corner[i], corner[j]);
          check(tag_of(3'(o)), e[33:2], e[1], e[0]);
        end
      end
    end

    // random operands under every code
    for (int k = 0; k < 400; k++) begin
      logic [2:0] ro;
      logic [31:0] ra, rb;
      ro = 3'($urandom % 8);
      ra = $urandom;
      rb = (k % 4 == 0) ? ra : $urandom;
      apply(ro, ra, rb);
      e = model(ro, ra, rb);
      check(tag_of(ro), e[33:2], e[1], e[0]);
    end

    summary();
  end
endmodule